// File: doc/BRIEF.md
# Boot-Mode Service-Request Pin Controller

This block owns one shared pin that a device uses during its flash-programming boot mode. Out of reset the pin is only sensed, never driven. When one serial host interface (I2C or SPI) has been chosen, the block turns the pin into an output. From then on the pin acts as an active-low service request towards the host. Three sources can choose the interface: a reinvoke request that names an interface, a stored configuration that is valid and names one, or the first probe command accepted by one of the two serial slave engines. Once an interface is chosen, it stays fixed until reset.

With the pin driven, the block runs the command/response exchange. A command arrives and is processed. If the command asks for it, the pin is then pulled low to signal that a response is ready. It stays low until the host asks for that response. The pin returns high in the same cycle as that request. The serial engines, the command parser and the flash logic sit outside this block and reach it only through single-cycle strobes.

Top module: `bootirq_pin_ctrl`

## Requirements
- R1: After reset, `pin_oe_o` is 0, `pin_out_o` is 1, `host_if_o` is 2'b00 (none) and `proto_err_o` is 0.
- R2: While nothing is selected, the output enable stays 0 in these cases: configuration invalid, or its interface field not 2'b01/2'b10, with no accepted probe and no reinvoke naming 2'b01/2'b10. This is auto-detect.
- R3: In auto-detect, an accepted I2C probe selects 2'b01 and an accepted SPI probe selects 2'b10. The selection shows on `host_if_o` and `pin_oe_o`=1 with `pin_out_o`=1 on the next cycle. If both probes arrive together, I2C wins.
- R4: A valid configuration whose field is 2'b01 (I2C) or 2'b10 (SPI) selects that interface on the next cycle, with no probe.
- R5: A reinvoke request whose field is 2'b01 or 2'b10 selects that interface on the next cycle. When several sources act in the same cycle, reinvoke beats configuration, and configuration beats probes.
- R6: Once selected, `host_if_o` and `pin_oe_o` stay fixed until reset. Later probes, configuration changes and reinvoke requests have no effect.
- R7: Handshake strobes seen before an interface is selected are ignored.
- R8: After a command, a processing-done strobe with `assert_irq_en_i`=1 drives `pin_out_o` low from the next cycle.
- R9: A processing-done strobe with `assert_irq_en_i`=0 completes the command without driving the pin low. A new command may then follow.
- R10: Once low, `pin_out_o` stays low until `resp_read_req_i`. It is high in the same cycle the request is seen and stays high afterwards.
- R11: A command that arrives while a response is pending, without a response request in the same cycle, pulses `proto_err_o` for one cycle on the next cycle. The pin stays low. A command that arrives together with the response request is accepted without error.
- R12: A processing-done strobe with no command in progress has no effect, and neither does a response request with no response pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_valid_i | input | 1 | Stored boot configuration is valid |
| cfg_if_i | input | 2 | Interface named by configuration (01 I2C, 10 SPI) |
| probe_i2c_ok_i | input | 1 | Probe command accepted on I2C (strobe) |
| probe_spi_ok_i | input | 1 | Probe command accepted on SPI (strobe) |
| reinvoke_req_i | input | 1 | Reinvoke request (strobe) |
| reinvoke_if_i | input | 2 | Interface named by the reinvoke request |
| cmd_received_i | input | 1 | Command packet received (strobe) |
| proc_done_i | input | 1 | Command processing finished (strobe) |
| assert_irq_en_i | input | 1 | Current command requests the service pin |
| resp_read_req_i | input | 1 | Host requests the response (strobe) |
| pin_oe_o | output | 1 | Pin output enable |
| pin_out_o | output | 1 | Pin output level, low means service needed |
| host_if_o | output | 2 | Selected interface: 00 none, 01 I2C, 10 SPI |
| proto_err_o | output | 1 | One-cycle pulse: command while response pending |

## Verification
A selection register that was wrong or not held would show on `host_if_o` and `pin_oe_o` one cycle after the deciding strobe. It would also show at any later cycle in which it drifted. A wrong handshake state shows on `pin_out_o`. The pin falls one cycle after processing ends, or fails to fall. It returns high in the same cycle as a response request, or it does not. A missed error pulse is visible one cycle after the offending command. Every selection source is swept over all four field codes, and the handshake is swept over the irq-enable flag, processing delays and holding times.

// File: rtl/bootirq_pkg.sv
package bootirq_pkg;

    localparam int IF_W = 2;

    typedef enum logic [IF_W-1:0] {
        HOST_NONE = 2'd0,
        HOST_I2C  = 2'd1,
        HOST_SPI  = 2'd2
    } host_if_e;

    typedef enum logic [1:0] {
        HS_IDLE = 2'd0,
        HS_BUSY = 2'd1,
        HS_PEND = 2'd2
    } hs_state_e;

    function automatic logic if_code_ok(input logic [IF_W-1:0] code);
        return (code == HOST_I2C) || (code == HOST_SPI);
    endfunction

endpackage

// File: rtl/bootirq_if_select.sv
module bootirq_if_select
    import bootirq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_valid_i,
    input  logic [IF_W-1:0] cfg_if_i,
    input  logic            probe_i2c_i,
    input  logic            probe_spi_i,
    input  logic            reinv_req_i,
    input  logic [IF_W-1:0] reinv_if_i,
    output host_if_e        host_sel_o,
    output logic            sel_done_o
);

    typedef struct packed {
        host_if_e sel;
    } sel_regs_t;

    sel_regs_t sel_d, sel_q;

    // Selection is taken once; priority reinvoke > configuration > probes.
    always_comb begin
        sel_d = sel_q;
        if (sel_q.sel == HOST_NONE) begin
            if (reinv_req_i && if_code_ok(reinv_if_i)) begin
                sel_d.sel = host_if_e'(reinv_if_i);
            end else if (cfg_valid_i && if_code_ok(cfg_if_i)) begin
                sel_d.sel = host_if_e'(cfg_if_i);
            end else if (probe_i2c_i) begin
                sel_d.sel = HOST_I2C;
            end else if (probe_spi_i) begin
                sel_d.sel = HOST_SPI;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '{sel: HOST_NONE};
        end else begin
            sel_q <= sel_d;
        end
    end

    assign host_sel_o = sel_q.sel;
    assign sel_done_o = (sel_q.sel != HOST_NONE);

endmodule

// File: rtl/bootirq_handshake.sv
module bootirq_handshake
    import bootirq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable_i,
    input  logic cmd_i,
    input  logic done_i,
    input  logic irq_en_i,
    input  logic read_i,
    output logic pending_o,
    output logic proto_err_o
);

    typedef struct packed {
        hs_state_e st;
        logic      err;
    } hs_regs_t;

    hs_regs_t hs_d, hs_q;

    always_comb begin
        hs_d     = hs_q;
        hs_d.err = 1'b0;
        if (enable_i) begin
            unique case (hs_q.st)
                HS_IDLE: begin
                    if (cmd_i) hs_d.st = HS_BUSY;
                end
                HS_BUSY: begin
                    if (done_i) hs_d.st = irq_en_i ? HS_PEND : HS_IDLE;
                end
                HS_PEND: begin
                    if (read_i) begin
                        hs_d.st = cmd_i ? HS_BUSY : HS_IDLE;
                    end else if (cmd_i) begin
                        hs_d.err = 1'b1;
                    end
                end
                default: hs_d.st = HS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_q <= '{st: HS_IDLE, err: 1'b0};
        end else begin
            hs_q <= hs_d;
        end
    end

    assign pending_o   = (hs_q.st == HS_PEND);
    assign proto_err_o = hs_q.err;

endmodule

// File: rtl/bootirq_pin_drive.sv
module bootirq_pin_drive (
    input  logic sel_done_i,
    input  logic pending_i,
    input  logic read_i,
    output logic pin_oe_o,
    output logic pin_out_o
);

    // Release is combinational so the pin rises in the request cycle.
    always_comb begin
        pin_oe_o  = sel_done_i;
        pin_out_o = !(pending_i && !read_i);
    end

endmodule

// File: rtl/bootirq_pin_ctrl.sv
module bootirq_pin_ctrl
    import bootirq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_valid_i,
    input  logic [IF_W-1:0] cfg_if_i,
    input  logic            probe_i2c_ok_i,
    input  logic            probe_spi_ok_i,
    input  logic            reinvoke_req_i,
    input  logic [IF_W-1:0] reinvoke_if_i,
    input  logic            cmd_received_i,
    input  logic            proc_done_i,
    input  logic            assert_irq_en_i,
    input  logic            resp_read_req_i,
    output logic            pin_oe_o,
    output logic            pin_out_o,
    output logic [IF_W-1:0] host_if_o,
    output logic            proto_err_o
);

    host_if_e host_sel;
    logic     sel_done;
    logic     pending;

    bootirq_if_select u_sel (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_valid_i (cfg_valid_i),
        .cfg_if_i    (cfg_if_i),
        .probe_i2c_i (probe_i2c_ok_i),
        .probe_spi_i (probe_spi_ok_i),
        .reinv_req_i (reinvoke_req_i),
        .reinv_if_i  (reinvoke_if_i),
        .host_sel_o  (host_sel),
        .sel_done_o  (sel_done)
    );

    bootirq_handshake u_hs (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable_i    (sel_done),
        .cmd_i       (cmd_received_i),
        .done_i      (proc_done_i),
        .irq_en_i    (assert_irq_en_i),
        .read_i      (resp_read_req_i),
        .pending_o   (pending),
        .proto_err_o (proto_err_o)
    );

    bootirq_pin_drive u_pin (
        .sel_done_i (sel_done),
        .pending_i  (pending),
        .read_i     (resp_read_req_i),
        .pin_oe_o   (pin_oe_o),
        .pin_out_o  (pin_out_o)
    );

    assign host_if_o = host_sel;

endmodule

// File: rtl/bootirq_pin_ctrl_chk.sv
module bootirq_pin_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_valid_i,
    input logic [1:0] cfg_if_i,
    input logic       probe_i2c_ok_i,
    input logic       probe_spi_ok_i,
    input logic       reinvoke_req_i,
    input logic [1:0] reinvoke_if_i,
    input logic       cmd_received_i,
    input logic       proc_done_i,
    input logic       assert_irq_en_i,
    input logic       resp_read_req_i,
    input logic       pin_oe_o,
    input logic       pin_out_o,
    input logic [1:0] host_if_o,
    input logic       proto_err_o
);

    assert_probe_i2c_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!pin_oe_o && probe_i2c_ok_i && !reinvoke_req_i && !cfg_valid_i)
        |=> (pin_oe_o && host_if_o == 2'b01));

    assert_sel_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pin_oe_o |=> (pin_oe_o && $stable(host_if_o)));

    assert_no_irq_unselected_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_out_o |-> pin_oe_o);

    assert_irq_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!pin_out_o && !resp_read_req_i) |=> (!pin_out_o || resp_read_req_i));

    assert_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        resp_read_req_i |=> pin_out_o);

    assert_err_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err_o |-> (!pin_out_o && $past(cmd_received_i)));

endmodule

bind bootirq_pin_ctrl bootirq_pin_ctrl_chk chk_i (.*);

// File: tb/bootirq_pin_ctrl_tb_top.sv
module bootirq_pin_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cfg_valid_i, probe_i2c_ok_i, probe_spi_ok_i, reinvoke_req_i;
    logic [1:0] cfg_if_i, reinvoke_if_i;
    logic       cmd_received_i, proc_done_i, assert_irq_en_i, resp_read_req_i;
    logic       pin_oe_o, pin_out_o, proto_err_o;
    logic [1:0] host_if_o;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    bootirq_pin_ctrl dut_i (.*);

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: act=%0d cycles exp<=20000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_in();
        cfg_valid_i = 0; cfg_if_i = 0; probe_i2c_ok_i = 0; probe_spi_ok_i = 0;
        reinvoke_req_i = 0; reinvoke_if_i = 0; cmd_received_i = 0;
        proc_done_i = 0; assert_irq_en_i = 0; resp_read_req_i = 0;
    endtask

    task automatic do_reset();
        clear_in();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    // Expected selection from a field code: only 01/10 are valid.
    function automatic logic [1:0] code_sel(input logic [1:0] c);
        return (c == 2'b01 || c == 2'b10) ? c : 2'b00;
    endfunction

    task automatic select_i2c();
        probe_i2c_ok_i = 1;
        tick();
        probe_i2c_ok_i = 0;
    endtask

    initial begin
        logic [1:0] exp_sel;
        do_reset();
        // R1 reset state
        chk("R1 oe", pin_oe_o, 0);
        chk("R1 out", pin_out_o, 1);
        chk("R1 if", host_if_o, 0);
        chk("R1 err", proto_err_o, 0);

        // R2 invalid configuration with any field leaves auto-detect
        for (int c = 0; c < 4; c++) begin
            do_reset();
            cfg_valid_i = 0; cfg_if_i = 2'(c);
            tick(); tick();
            chk("R2 oe invalid cfg", pin_oe_o, 0);
            chk("R2 if invalid cfg", host_if_o, 0);
        end

        // Sweep each source over all four codes
        for (int path = 0; path < 3; path++) begin
            for (int c = 0; c < 4; c++) begin
                do_reset();
                if (path == 0) begin
                    probe_i2c_ok_i = c[0]; probe_spi_ok_i = c[1];
                    exp_sel = c[0] ? 2'b01 : (c[1] ? 2'b10 : 2'b00);
                end else if (path == 1) begin
                    cfg_valid_i = 1; cfg_if_i = 2'(c);
                    exp_sel = code_sel(2'(c));
                end else begin
                    reinvoke_req_i = 1; reinvoke_if_i = 2'(c);
                    exp_sel = code_sel(2'(c));
                end
                tick();
                clear_in();
                chk(path == 0 ? "R3 probe if" : (path == 1 ? "R4 cfg if" : "R5 reinvoke if"),
                    host_if_o, exp_sel);
                chk(path == 0 ? "R3 probe oe" : (path == 1 ? "R4 cfg oe" : "R5 reinvoke oe"),
                    pin_oe_o, exp_sel != 0);
                chk("R3 pin high after select", pin_out_o, 1);
                if (exp_sel != 0) begin
                    // R6 other sources afterwards have no effect
                    probe_i2c_ok_i = 1; probe_spi_ok_i = 1;
                    reinvoke_req_i = 1; reinvoke_if_i = ~exp_sel;
                    cfg_valid_i = 1; cfg_if_i = ~exp_sel;
                    tick();
                    clear_in();
                    tick();
                    chk("R6 if held", host_if_o, exp_sel);
                    chk("R6 oe held", pin_oe_o, 1);
                end
            end
        end

        // R5 priority: reinvoke SPI beats cfg I2C and probe I2C
        do_reset();
        reinvoke_req_i = 1; reinvoke_if_i = 2'b10;
        cfg_valid_i = 1; cfg_if_i = 2'b01; probe_i2c_ok_i = 1;
        tick(); clear_in();
        chk("R5 reinvoke priority", host_if_o, 2'b10);
        // R5 cfg SPI beats probe I2C
        do_reset();
        cfg_valid_i = 1; cfg_if_i = 2'b10; probe_i2c_ok_i = 1;
        tick(); clear_in();
        chk("R5 cfg over probe", host_if_o, 2'b10);

        // R7 strobes before selection are ignored
        do_reset();
        cmd_received_i = 1; tick(); clear_in();
        proc_done_i = 1; assert_irq_en_i = 1; tick(); clear_in();
        chk("R7 pin before select", pin_out_o, 1);
        select_i2c();
        proc_done_i = 1; assert_irq_en_i = 1; tick(); clear_in();
        chk("R7 no stale command", pin_out_o, 1);

        // R8/R9/R10 handshake sweep
        for (int en = 0; en < 2; en++) begin
            for (int w = 0; w < 4; w++) begin
                for (int h = 0; h < 4; h++) begin
                    do_reset();
                    select_i2c();
                    cmd_received_i = 1; tick(); cmd_received_i = 0;
                    for (int k = 0; k < w; k++) begin
                        tick();
                        chk("R8 high while busy", pin_out_o, 1);
                    end
                    proc_done_i = 1; assert_irq_en_i = 1'(en);
                    tick(); clear_in();
                    chk(en ? "R8 irq low" : "R9 no irq", pin_out_o, en ? 0 : 1);
                    for (int k = 0; k < h; k++) begin
                        tick();
                        chk(en ? "R10 irq held" : "R9 stays high", pin_out_o, en ? 0 : 1);
                    end
                    resp_read_req_i = 1;
                    #1;
                    chk("R10 same-cycle release", pin_out_o, 1);
                    tick(); clear_in();
                    chk("R10 high after read", pin_out_o, 1);
                    // R9/R12: next command works after completion
                    cmd_received_i = 1; tick(); clear_in();
                    proc_done_i = 1; assert_irq_en_i = 1; tick(); clear_in();
                    chk("R9 next command irq", pin_out_o, 0);
                end
            end
        end

        // R11 command while pending
        do_reset();
        select_i2c();
        cmd_received_i = 1; tick(); clear_in();
        proc_done_i = 1; assert_irq_en_i = 1; tick(); clear_in();
        cmd_received_i = 1; tick(); clear_in();
        chk("R11 err pulse", proto_err_o, 1);
        chk("R11 irq kept", pin_out_o, 0);
        tick();
        chk("R11 err one cycle", proto_err_o, 0);
        chk("R11 irq still low", pin_out_o, 0);
        // R11 command together with read: accepted, no error
        cmd_received_i = 1; resp_read_req_i = 1;
        #1;
        chk("R11 release with cmd", pin_out_o, 1);
        tick(); clear_in();
        chk("R11 no err with read", proto_err_o, 0);
        proc_done_i = 1; assert_irq_en_i = 1; tick(); clear_in();
        chk("R11 cmd accepted", pin_out_o, 0);

        // R12 stray strobes
        do_reset();
        select_i2c();
        proc_done_i = 1; assert_irq_en_i = 1; tick(); clear_in();
        chk("R12 stray done", pin_out_o, 1);
        resp_read_req_i = 1; tick(); clear_in();
        chk("R12 stray read", pin_out_o, 1);
        cmd_received_i = 1; tick(); clear_in();
        proc_done_i = 1; assert_irq_en_i = 1; tick(); clear_in();
        chk("R12 state intact", pin_out_o, 0);
        chk("R12 no err", proto_err_o, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule